// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block holds the digital control of a sampling successive-approximation converter. Three active-low strobes (convert request, read, chip select) arrive asynchronously. They are synchronized and combined to start conversions. While a conversion runs, the block holds the track/hold in hold, and it resolves one result bit per conversion-clock tick from a single comparator-decision input. It then latches a 12-bit two's-complement result and presents it on a data bus whose enable follows read and chip select. The conversion clock is a tick that a prescaler derives from the system clock.

A static two-bit strap selects the function of the status pin. It can be an end-of-conversion interrupt that a read clears, or a busy flag. The third setting is a free-running mode: while every strobe is held low, a new conversion follows each one with two ticks of tracking in between. The usual strapping schemes need no extra logic. They are full control, stand-alone (read and select tied low), memory-style (convert request tied low, reads start conversions) and continuous. The trial word that drives the DAC is brought out, so a testbench can compare it against any emulated input level.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Every control input passes through two flops. A conversion starts when the synchronized convert request falls, or when read and select become jointly low while the convert request is already low. Each such start lifts `th_hold` at the third rising clock edge after the input change. While the convert request is high, no conversion starts.
- R2: Start events that arrive while a conversion is in progress are dropped, not queued. Once the conversion ends, the block stays idle until a fresh start event.
- R3: A conversion lasts 13 conversion-clock ticks after the start cycle. If the start is detected in a cycle that carries a tick, it lasts 14 ticks. A tick occurs in every TICK_DIV-th clock cycle after reset, in cycles TICK_DIV-1, 2*TICK_DIV-1, and so on.
- R4: `th_hold` is high from the cycle after the start until the final tick. `dac_trial` starts at 0x800. On each of the last 12 ticks the current bit, MSB first, takes `comp_in`, where 1 means the input is at or above the trial word, and the next lower bit is set to 1.
- R5: With `mode_sel`=0 (interrupt), `stat_n` goes low after the final tick. It returns high the cycle after read and select are seen jointly low, as synchronized.
- R6: With `mode_sel`=1 or 3 (busy), and also with 2, `stat_n` is low exactly while `th_hold` is high.
- R7: `data_oe` is high exactly when the synchronized read and select are both low, with the same three-edge latency as R1. While `data_oe` is low, `data_out` reads zero.
- R8: The result register updates only at the final tick of a conversion. It holds the 12-bit SAR word with its MSB inverted, which is two's complement. The previous result stays readable throughout a conversion.
- R9: With `mode_sel`=2 and all strobes held low, each conversion is followed by exactly 2 ticks in track and then a 12-tick hold, so conversions repeat every 14 ticks. If any strobe is high when a conversion ends or during the gap, the repetition stops.
- R10: A synchronous active-high reset gives `th_hold`=0, `stat_n`=1, `data_oe`=0, `data_out`=0 and `dac_trial`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Static strap: 0 interrupt, 1/3 busy, 2 free-running busy |
| conv_n | input | 1 | Convert request, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| comp_in | input | 1 | Comparator decision: input at or above trial word |
| th_hold | output | 1 | Track/hold control, 1 = hold |
| stat_n | output | 1 | Interrupt or busy status, active low |
| data_oe | output | 1 | Output enable for the three-state data bus |
| data_out | output | 12 | Conversion result, two's complement |
| dac_trial | output | 12 | SAR trial word for the DAC, offset binary |

## Verification
The hardest case to reach from the ports is the 14-tick conversion, because the start must be detected in exactly the cycle that carries a tick. The bench tracks the tick phase by counting clocks since reset. It changes the convert request at the falling edge whose following two synchronizer stages put the detection on a tick cycle, and it also drives a start one phase off so that the 13-tick case is covered. Two other cases need deliberate stimulus. A second convert-request edge is driven in the middle of a running conversion, and a chip select is raised during a free-running conversion, so that the stop takes effect only at the next restart point.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_ACQ  = 2'd2
    } conv_state_e;

    localparam logic [1:0] STRAP_IRQ  = 2'd0;
    localparam logic [1:0] STRAP_FREE = 2'd2;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] st1_q, st2_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic st1_d, st2_d;

        always_comb begin
            st1_d = async_in[i];
            st2_d = st1_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st1_q[i] <= 1'b1;
                st2_q[i] <= 1'b1;
            end else begin
                st1_q[i] <= st1_d;
                st2_q[i] <= st2_d;
            end
        end
    end

    assign sync_out = st2_q;
endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (pre_q == LAST);
        pre_d = tick ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_adc_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_sel,
    input  logic         conv_s,
    input  logic         rd_s,
    input  logic         cs_s,
    input  logic         tick,
    input  logic         comp_in,
    output logic         hold,
    output logic         stat_n,
    output logic         oe,
    output logic [W-1:0] result,
    output logic [W-1:0] trial
);
    localparam int CW = $clog2(W + 3);
    localparam logic [CW-1:0] CNT_EARLY = CW'(W + 1);
    localparam logic [CW-1:0] CNT_LATE  = CW'(W + 2);
    localparam logic [CW-1:0] CNT_FREE  = CW'(W);
    localparam logic [W-1:0]  MSB_ONLY  = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        conv_state_e   st;
        logic [CW-1:0] cnt;
        logic          acq;
        logic [W-1:0]  sar;
        logic [W-1:0]  result;
        logic          stat_n;
        logic          hold;
        logic          oe;
        logic          conv_prev;
        logic          rdcs_prev;
    } core_t;

    core_t d, q;
    logic  rdcs, all_low, start_evt, done, is_irq, is_free;

    always_comb begin
        is_irq    = (mode_sel == STRAP_IRQ);
        is_free   = (mode_sel == STRAP_FREE);
        rdcs      = !rd_s && !cs_s;
        all_low   = rdcs && !conv_s;
        start_evt = (!conv_s && q.conv_prev) || (all_low && !q.rdcs_prev);
    end

    always_comb begin
        d           = q;
        done        = 1'b0;
        d.conv_prev = conv_s;
        d.rdcs_prev = rdcs;
        d.oe        = rdcs;
        if (is_irq && rdcs) d.stat_n = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (start_evt) begin
                    d.st   = ST_CONV;
                    d.cnt  = tick ? CNT_LATE : CNT_EARLY;
                    d.sar  = MSB_ONLY;
                    d.hold = 1'b1;
                    if (!is_irq) d.stat_n = 1'b0;
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (q.cnt <= CW'(W)) begin
                        for (int i = 0; i < W; i++) begin
                            if (CW'(i + 1) == q.cnt) d.sar[i] = comp_in;
                            if (CW'(i + 2) == q.cnt) d.sar[i] = 1'b1;
                        end
                    end
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CW'(1)) begin
                        done     = 1'b1;
                        d.hold   = 1'b0;
                        d.result = {~d.sar[W-1], d.sar[W-2:0]};
                        d.stat_n = !is_irq;
                        d.acq    = 1'b0;
                        d.st     = (is_free && all_low) ? ST_ACQ : ST_IDLE;
                    end
                end
            end
            ST_ACQ: begin
                if (!all_low) begin
                    d.st = ST_IDLE;
                end else if (tick) begin
                    if (q.acq) begin
                        d.st     = ST_CONV;
                        d.cnt    = CNT_FREE;
                        d.sar    = MSB_ONLY;
                        d.hold   = 1'b1;
                        d.stat_n = 1'b0;
                        d.acq    = 1'b0;
                    end else begin
                        d.acq = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st        <= ST_IDLE;
            q.cnt       <= '0;
            q.acq       <= 1'b0;
            q.sar       <= '0;
            q.result    <= '0;
            q.stat_n    <= 1'b1;
            q.hold      <= 1'b0;
            q.oe        <= 1'b0;
            q.conv_prev <= 1'b1;
            q.rdcs_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hold   = q.hold;
    assign stat_n = q.stat_n;
    assign oe     = q.oe;
    assign result = q.result;
    assign trial  = q.sar;

    AST_START_NEEDS_CONV_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(q.hold) |-> $past(!conv_s)); // R1
    AST_NO_RELOAD_MIDWAY: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_CONV && !tick) |=> (q.st == ST_CONV && $stable(q.cnt))); // R2
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_CONV) |-> (q.cnt != '0)); // R3
    AST_HOLD_WHILE_CONV: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_CONV) |-> q.hold); // R4
    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (is_irq && $past(done)) |-> !q.stat_n); // R5
    AST_BUSY_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !is_irq |-> (q.stat_n == !q.hold)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(done) |-> $stable(q.result)); // R8
    AST_TRACK_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_ACQ) |-> !q.hold); // R9
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int W        = 12,
    parameter int TICK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_sel,
    input  logic         conv_n,
    input  logic         rd_n,
    input  logic         cs_n,
    input  logic         comp_in,
    output logic         th_hold,
    output logic         stat_n,
    output logic         data_oe,
    output logic [W-1:0] data_out,
    output logic [W-1:0] dac_trial
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] strobes_s;
    logic             tick;
    logic [W-1:0]     result;

    sar_sync #(.N(NSYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({conv_n, rd_n, cs_n}),
        .sync_out (strobes_s)
    );

    sar_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sar_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .conv_s   (strobes_s[2]),
        .rd_s     (strobes_s[1]),
        .cs_s     (strobes_s[0]),
        .tick     (tick),
        .comp_in  (comp_in),
        .hold     (th_hold),
        .stat_n   (stat_n),
        .oe       (data_oe),
        .result   (result),
        .trial    (dac_trial)
    );

    assign data_out = data_oe ? result : '0;
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    localparam int W   = 12;
    localparam int DIV = 4;
    localparam int MID = 1 << (W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic conv_n = 1'b1, rd_n = 1'b1, cs_n = 1'b1;
    int   vin = 0;
    logic comp;
    logic hold, stat, oe;
    logic [W-1:0] dout, trial;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    assign comp = (vin >= int'(trial));

    sar_adc_ctrl #(.W(W), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode), .conv_n(conv_n), .rd_n(rd_n),
        .cs_n(cs_n), .comp_in(comp), .th_hold(hold), .stat_n(stat),
        .data_oe(oe), .data_out(dout), .dac_trial(trial)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced at each rising edge
    bit m_c1, m_c2, m_r1, m_r2, m_x1, m_x2, m_cprev, m_rprev;
    bit m_stat, m_hold, m_oe;
    int m_ph, m_left, m_acq, m_sar, m_res, m_k;

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = 1; m_c2 = 1; m_r1 = 1; m_r2 = 1; m_x1 = 1; m_x2 = 1;
            m_cprev = 1; m_rprev = 0; m_ph = 0; m_left = 0; m_acq = 0;
            m_sar = 0; m_res = 0; m_stat = 1; m_hold = 0; m_oe = 0; m_k = 0;
        end else begin
            bit tk, cl, rc, al, go, cmp, stt, hld;
            int ph, left, acq, sar, res, b;
            tk  = (m_k % DIV) == DIV - 1;
            cl  = !m_c2;
            rc  = !m_r2 && !m_x2;
            al  = cl && rc;
            go  = (cl && m_cprev) || (al && !m_rprev);
            cmp = (vin >= m_sar);
            ph = m_ph; left = m_left; acq = m_acq; sar = m_sar; res = m_res;
            stt = m_stat; hld = m_hold;
            if (mode == 0 && rc) stt = 1;
            if (m_ph == 0) begin
                if (go) begin
                    ph = 1; left = tk ? W + 2 : W + 1; sar = MID; hld = 1;
                    if (mode != 0) stt = 0;
                end
            end else if (m_ph == 1) begin
                if (tk) begin
                    if (m_left <= W) begin
                        b = m_left - 1;
                        sar = (sar & ~(1 << b)) | (int'(cmp) << b);
                        if (b > 0) sar = sar | (1 << (b - 1));
                    end
                    left = m_left - 1;
                    if (m_left == 1) begin
                        hld = 0; res = sar ^ MID; stt = (mode == 0) ? 0 : 1;
                        acq = 0; ph = (mode == 2 && al) ? 2 : 0;
                    end
                end
            end else begin
                if (!al) ph = 0;
                else if (tk) begin
                    if (m_acq != 0) begin
                        ph = 1; left = W; sar = MID; hld = 1; stt = 0; acq = 0;
                    end else acq = 1;
                end
            end
            m_ph = ph; m_left = left; m_acq = acq; m_sar = sar; m_res = res;
            m_stat = stt; m_hold = hld; m_oe = rc;
            m_cprev = m_c2; m_rprev = rc;
            m_c2 = m_c1; m_c1 = conv_n;
            m_r2 = m_r1; m_r1 = rd_n;
            m_x2 = m_x1; m_x1 = cs_n;
            m_k++;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R4 hold", int'(hold), int'(m_hold));
            chk((mode == 0) ? "R5 status" : "R6 status", int'(stat), int'(m_stat));
            chk("R7 enable", int'(oe), int'(m_oe));
            chk("R8 data", int'(dout), m_oe ? m_res : 0);
            chk("R4 trial", int'(trial), m_sar);
        end
    end

    task automatic do_reset(input logic [1:0] md, input logic c, input logic r, input logic s);
        @(negedge clk);
        rst = 1; mode = md; conv_n = c; rd_n = r; cs_n = s;
        repeat (2) @(negedge clk);
        chk("R10 reset hold", int'(hold), 0);
        chk("R10 reset status", int'(stat), 1);
        chk("R10 reset enable", int'(oe), 0);
        chk("R10 reset data", int'(dout), 0);
        chk("R10 reset trial", int'(trial), 0);
        rst = 0;
    endtask

    task automatic wait_phase(input int p);
        do @(negedge clk); while ((m_k % DIV) != p);
    endtask

    task automatic measure_hold(output int len);
        int guard;
        guard = 0;
        len = 0;
        while (hold !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
        while (hold === 1'b1 && len < 400) begin @(negedge clk); len++; end
    endtask

    task automatic count_low(output int len);
        len = 0;
        while (hold !== 1'b1 && len < 400) begin @(negedge clk); len++; end
    endtask

    int len, tr, hi_seen;

    initial begin
        // interrupt strap, start off the tick: 13 ticks
        do_reset(2'd0, 1, 1, 1);
        vin = 1234;
        wait_phase(3);
        conv_n = 0;
        measure_hold(len);
        chk("R3 short conversion cycles", len, 50);
        chk("R5 interrupt low at end", int'(stat), 0);
        chk("R7 bus off without read", int'(oe), 0);
        conv_n = 1;
        repeat (4) @(negedge clk);
        rd_n = 0; cs_n = 0;
        repeat (4) @(negedge clk);
        chk("R5 interrupt cleared by read", int'(stat), 1);
        chk("R7 bus on during read", int'(oe), 1);
        chk("R8 twos complement 1234", int'(dout), 1234 ^ MID);
        repeat (10) @(negedge clk);
        chk("R1 read with request high starts nothing", int'(hold), 0);
        rd_n = 1; cs_n = 1;

        // start detected on a tick: 14 ticks
        repeat (3) @(negedge clk);
        vin = 0;
        wait_phase(1);
        conv_n = 0;
        measure_hold(len);
        chk("R3 long conversion cycles", len, 56);
        conv_n = 1; rd_n = 0; cs_n = 0;
        repeat (4) @(negedge clk);
        chk("R8 most negative code", int'(dout), MID);
        rd_n = 1; cs_n = 1;

        // busy strap, mid-conversion request edge dropped
        do_reset(2'd1, 1, 1, 1);
        vin = 4095;
        repeat (2) @(negedge clk);
        conv_n = 0;
        while (hold !== 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R6 busy low during conversion", int'(stat), 0);
        conv_n = 1;
        repeat (3) @(negedge clk);
        conv_n = 0;
        len = 0;
        while (hold === 1'b1 && len < 400) begin @(negedge clk); len++; end
        chk("R6 busy released with hold", int'(stat), 1);
        hi_seen = 0;
        repeat (40) begin @(negedge clk); if (hold === 1'b1) hi_seen++; end
        chk("R2 dropped edge did not restart", hi_seen, 0);

        // memory style: request low, read strobes start conversion
        vin = 2047;
        rd_n = 0; cs_n = 0;
        while (hold !== 1'b1) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R1 read start with request low", int'(hold), 1);
        chk("R8 previous result during conversion", int'(dout), 4095 ^ MID);
        while (hold === 1'b1) @(negedge clk);
        chk("R8 new result after conversion", int'(dout), 2047 ^ MID);
        rd_n = 1; cs_n = 1; conv_n = 1;

        // free-running strap with all strobes held low
        do_reset(2'd2, 0, 0, 0);
        vin = 100;
        measure_hold(len);
        count_low(tr);
        measure_hold(len);
        count_low(tr);
        chk("R9 repeat hold cycles", len, 48);
        chk("R9 track gap cycles", tr, 8);
        chk("R9 period cycles", len + tr, 56);
        chk("R8 free-running data", int'(dout), 100 ^ MID);
        cs_n = 1;
        while (hold === 1'b1) @(negedge clk);
        hi_seen = 0;
        repeat (80) begin @(negedge clk); if (hold === 1'b1) hi_seen++; end
        chk("R9 stop after select raised", hi_seen, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule